// File: doc/BRIEF.md
# Programmable Threshold Comparator with Pickup and Reset Timers

The block combines two signed 8-bit arguments into one operating quantity. A select input chooses either their difference or their sum, and an integer scale factor multiplies the result. The scaled quantity is compared against a programmable threshold. The comparison can use the signed value or its magnitude, can trigger when the value is over or under the threshold, and has hysteresis on the dropout side.

A pickup flag follows the comparison on the next clock edge. An operate flag follows the pickup flag only after a pickup delay has run out, and it is released only after a reset delay has run out. Both delays are counted in ticks of a tick-enable input. A block input forces the element inactive. When the block input is released, the element resumes at once, and timing starts from that moment.

Top module: `thr_cmp_timer`

## Requirements
- R1: Arguments are 8-bit two's complement values (bit 7 is the sign). On every clock edge `quant_o` registers a 13-bit signed value: (A − B)·S when `add_sel_i`=0, or (A + B)·S when `add_sel_i`=1, where S is `scale_i`. The sum or difference is formed at 9 bits, so it never overflows.
- R2: A change of `add_sel_i` shows in `quant_o` and in the comparison on the very next clock edge, with no extra latency.
- R3: With `abs_mode_i`=0 the comparison uses the signed quantity. With `abs_mode_i`=1 it uses the magnitude of the combined quantity.
- R4: With `under_i`=0 (over), `pkp_o` rises on the edge where the compared value is strictly greater than `pickup_lvl_i` (signed). With `under_i`=1 (under), it rises where the compared value is strictly less than the threshold.
- R5: Once `pkp_o` is set, it stays set while the compared value is strictly beyond the dropout level, and it clears otherwise. The dropout level is threshold − `hyst_i` in over mode and threshold + `hyst_i` in under mode, with `hyst_i` unsigned.
- R6: While `pkp_o`=1 and `op_o`=0, the block counts ticks. `op_o` rises on the first edge at which the count already equals `pkp_dly_i`. With `tick_i` held high and N = `pkp_dly_i`, this is N+1 edges after `pkp_o` rose. N=0 sets `op_o` on the next edge.
- R7: While `pkp_o`=0 and `op_o`=1, the block counts ticks against `rst_dly_i` in the same way, and then clears `op_o`.
- R8: If `pkp_o` returns to the state of `op_o` before the delay runs out, the count is cleared and `op_o` does not change.
- R9: The timers advance only on edges where `tick_i`=1.
- R10: Reset and an asserted `block_i` clear `pkp_o`, `op_o` and the timer count on the next edge, and keep them clear for as long as the condition lasts.
- R11: On the first edge with `block_i` low, `pkp_o` rises if the pickup condition holds, and the pickup delay counts from that edge.
- R12: `scale_i` is an unsigned multiplier from 0 to 15. A scale of 0 gives a quantity of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable |
| arg_a_i | input | 8 | Argument A, two's complement |
| arg_b_i | input | 8 | Argument B, two's complement |
| add_sel_i | input | 1 | 0: A−B, 1: A+B |
| block_i | input | 1 | Forces the element inactive |
| abs_mode_i | input | 1 | 0: signed compare, 1: magnitude compare |
| under_i | input | 1 | 0: over, 1: under |
| scale_i | input | 4 | Integer scale factor |
| pickup_lvl_i | input | 13 | Signed pickup threshold (scaled units) |
| hyst_i | input | 13 | Unsigned hysteresis width |
| pkp_dly_i | input | 16 | Pickup delay in ticks |
| rst_dly_i | input | 16 | Reset delay in ticks |
| quant_o | output | 13 | Registered scaled operating quantity |
| pkp_o | output | 1 | Pickup flag |
| op_o | output | 1 | Operate flag |

## Verification
The assertions check on every cycle that:
- blocking clears both flags;
- the quantity tracks A when B is zero and the scale is one;
- a signed pickup lies strictly beyond the threshold on the side that matches the direction;
- the operate flag changes only in agreement with the previous pickup state;
- a zero pickup delay operates on the next edge.

Exact hysteresis dropout points, delay lengths under sparse ticks, timer cancellation, and release from blocking under a standing pickup condition show up only in the bench's scenarios. The bench compares every cycle against a model built from the requirements.

// File: rtl/thr_cmp_pkg.sv
package thr_cmp_pkg;
  typedef enum logic {DIR_OVER = 1'b0, DIR_UNDER = 1'b1} dir_e;
  typedef enum logic {CMP_SIGNED = 1'b0, CMP_MAG = 1'b1} cmp_mode_e;
endpackage

// File: rtl/opq_calc.sv
module opq_calc
  import thr_cmp_pkg::*;
#(
  parameter int ARG_W   = 8,
  parameter int SCALE_W = 4,
  localparam int SUM_W  = ARG_W + 1,
  localparam int QW     = SUM_W + SCALE_W
) (
  input  logic [ARG_W-1:0]   a_i,
  input  logic [ARG_W-1:0]   b_i,
  input  logic               add_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  cmp_mode_e          mode_i,
  output logic [QW-1:0]      quant_o,
  output logic [QW-1:0]      cmp_o
);
  logic signed [SUM_W-1:0] a_x, b_x, sum;
  logic signed [QW-1:0]    sum_x, scl_x, prod, mag;

  always_comb begin
    a_x   = {a_i[ARG_W-1], a_i};
    b_x   = {b_i[ARG_W-1], b_i};
    sum   = add_i ? (a_x + b_x) : (a_x - b_x);
    sum_x = {{SCALE_W{sum[SUM_W-1]}}, sum};
    scl_x = {{(QW-SCALE_W){1'b0}}, scale_i};
    prod  = sum_x * scl_x;
    mag   = prod[QW-1] ? -prod : prod;
  end

  assign quant_o = prod;
  assign cmp_o   = (mode_i == CMP_MAG) ? mag : prod;
endmodule

// File: rtl/lvl_det.sv
module lvl_det
  import thr_cmp_pkg::*;
#(
  parameter int QW = 13,
  localparam int CW = QW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blk_i,
  input  dir_e          dir_i,
  input  logic [QW-1:0] cmp_i,
  input  logic [QW-1:0] thr_i,
  input  logic [QW-1:0] hyst_i,
  output logic          pkp_o
);
  logic signed [CW-1:0] val_x, thr_x, hys_x, drop_x;
  logic pick, hold, pkp_q;

  always_comb begin
    val_x  = {{2{cmp_i[QW-1]}}, cmp_i};
    thr_x  = {{2{thr_i[QW-1]}}, thr_i};
    hys_x  = {2'b00, hyst_i};
    drop_x = (dir_i == DIR_UNDER) ? (thr_x + hys_x) : (thr_x - hys_x);
    if (dir_i == DIR_UNDER) begin
      pick = val_x < thr_x;
      hold = val_x < drop_x;
    end else begin
      pick = val_x > thr_x;
      hold = val_x > drop_x;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pkp_q <= 1'b0;
    else if (blk_i) pkp_q <= 1'b0;
    else            pkp_q <= pkp_q ? hold : pick;
  end

  assign pkp_o = pkp_q;
endmodule

// File: rtl/op_timer.sv
module op_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             blk_i,
  input  logic             pkp_i,
  input  logic [DLY_W-1:0] pkp_dly_i,
  input  logic [DLY_W-1:0] rst_dly_i,
  output logic             op_o
);
  logic [DLY_W-1:0] cnt_q, target;
  logic op_q, pending, expired;

  assign pending = pkp_i != op_q;
  assign target  = pkp_i ? pkp_dly_i : rst_dly_i;
  assign expired = cnt_q >= target;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= 1'b0;
      cnt_q <= '0;
    end else if (blk_i || !pending) begin
      if (blk_i) op_q <= 1'b0;
      cnt_q <= '0;
    end else if (expired) begin
      op_q  <= pkp_i;
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign op_o = op_q;
endmodule

// File: rtl/thr_cmp_timer.sv
module thr_cmp_timer
  import thr_cmp_pkg::*;
#(
  parameter int ARG_W   = 8,
  parameter int SCALE_W = 4,
  parameter int DLY_W   = 16,
  localparam int QW     = ARG_W + 1 + SCALE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [ARG_W-1:0]   arg_a_i,
  input  logic [ARG_W-1:0]   arg_b_i,
  input  logic               add_sel_i,
  input  logic               block_i,
  input  logic               abs_mode_i,
  input  logic               under_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [QW-1:0]      pickup_lvl_i,
  input  logic [QW-1:0]      hyst_i,
  input  logic [DLY_W-1:0]   pkp_dly_i,
  input  logic [DLY_W-1:0]   rst_dly_i,
  output logic [QW-1:0]      quant_o,
  output logic               pkp_o,
  output logic               op_o
);
  logic [QW-1:0] quant_c, cmp_c, quant_q;
  logic          pkp_w;

  opq_calc #(.ARG_W(ARG_W), .SCALE_W(SCALE_W)) u_opq (
    .a_i(arg_a_i), .b_i(arg_b_i), .add_i(add_sel_i), .scale_i(scale_i),
    .mode_i(cmp_mode_e'(abs_mode_i)), .quant_o(quant_c), .cmp_o(cmp_c)
  );

  lvl_det #(.QW(QW)) u_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni), .blk_i(block_i), .dir_i(dir_e'(under_i)),
    .cmp_i(cmp_c), .thr_i(pickup_lvl_i), .hyst_i(hyst_i), .pkp_o(pkp_w)
  );

  op_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .blk_i(block_i),
    .pkp_i(pkp_w), .pkp_dly_i(pkp_dly_i), .rst_dly_i(rst_dly_i), .op_o(op_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) quant_q <= '0;
    else         quant_q <= quant_c;
  end

  assign quant_o = quant_q;
  assign pkp_o   = pkp_w;
endmodule

// File: rtl/thr_cmp_timer_chk.sv
module thr_cmp_timer_chk #(
  parameter int ARG_W   = 8,
  parameter int SCALE_W = 4,
  parameter int DLY_W   = 16,
  localparam int QW     = ARG_W + 1 + SCALE_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [ARG_W-1:0]   arg_a_i,
  input logic [ARG_W-1:0]   arg_b_i,
  input logic               add_sel_i,
  input logic               block_i,
  input logic               abs_mode_i,
  input logic               under_i,
  input logic [SCALE_W-1:0] scale_i,
  input logic [QW-1:0]      pickup_lvl_i,
  input logic [QW-1:0]      hyst_i,
  input logic [DLY_W-1:0]   pkp_dly_i,
  input logic [DLY_W-1:0]   rst_dly_i,
  input logic [QW-1:0]      quant_o,
  input logic               pkp_o,
  input logic               op_o
);
  assert_block_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> (!pkp_o && !op_o));

  assert_quant_tracks_a_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arg_b_i == '0 && scale_i == SCALE_W'(1)) |=>
      quant_o == {{(QW-ARG_W){$past(arg_a_i[ARG_W-1])}}, $past(arg_a_i)});

  assert_over_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pkp_o) && !$past(under_i) && !$past(abs_mode_i)) |->
      $signed(quant_o) > $signed($past(pickup_lvl_i)));

  assert_under_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pkp_o) && $past(under_i) && !$past(abs_mode_i)) |->
      $signed(quant_o) < $signed($past(pickup_lvl_i)));

  assert_op_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(op_o) |-> $past(pkp_o));

  assert_op_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(op_o) |-> (!$past(pkp_o) || $past(block_i)));

  assert_zero_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkp_o && !op_o && pkp_dly_i == '0 && !block_i) |=> op_o);
endmodule

bind thr_cmp_timer thr_cmp_timer_chk #(.ARG_W(ARG_W), .SCALE_W(SCALE_W), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/thr_cmp_timer_tb.sv
module thr_cmp_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, add_sel, blk, abs_m, under;
  logic [7:0] a, b;
  logic [3:0] scale;
  logic [12:0] thr, hyst, quant;
  logic [15:0] pdly, rdly;
  logic pkp, op;

  int n_chk = 0, n_err = 0;
  bit m_pkp, m_op;
  int m_cnt, m_q;
  bit done = 0;

  always #5 clk = ~clk;

  thr_cmp_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .arg_a_i(a), .arg_b_i(b),
    .add_sel_i(add_sel), .block_i(blk), .abs_mode_i(abs_m), .under_i(under),
    .scale_i(scale), .pickup_lvl_i(thr), .hyst_i(hyst), .pkp_dly_i(pdly),
    .rst_dly_i(rdly), .quant_o(quant), .pkp_o(pkp), .op_o(op)
  );

  function automatic int f_quant(logic [7:0] xa, logic [7:0] xb, bit ad, logic [3:0] s);
    int sa = $signed(xa);
    int sb = $signed(xb);
    return (ad ? sa + sb : sa - sb) * int'(s);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    int q, v, t, d, tgt, n_cnt;
    bit pick, hold, n_pkp, n_op;
    q = f_quant(a, b, add_sel, scale);
    v = (abs_m && q < 0) ? -q : q;
    t = $signed(thr);
    d = under ? t + int'(hyst) : t - int'(hyst);
    pick = under ? (v < t) : (v > t);
    hold = under ? (v < d) : (v > d);
    n_op = m_op; n_cnt = 0;
    if (blk) n_op = 0;
    else if (m_pkp != m_op) begin
      tgt = m_pkp ? int'(pdly) : int'(rdly);
      if (m_cnt >= tgt) n_op = m_pkp;
      else n_cnt = m_cnt + (tick ? 1 : 0);
    end
    n_pkp = blk ? 0 : (m_pkp ? hold : pick);
    @(posedge clk); #1;
    m_q = q; m_pkp = n_pkp; m_op = n_op; m_cnt = n_cnt;
    chk(tag, "quant", $signed(quant), m_q);
    chk(tag, "pkp", int'(pkp), int'(m_pkp));
    chk(tag, "op", int'(op), int'(m_op));
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 12345;
    void'($urandom(seed));
    tick = 1; add_sel = 0; blk = 0; abs_m = 0; under = 0;
    a = 0; b = 0; scale = 1; thr = 13'd10; hyst = 0; pdly = 0; rdly = 0;
    m_pkp = 0; m_op = 0; m_cnt = 0; m_q = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "quant", $signed(quant), 0);
    chk("R10", "pkp", int'(pkp), 0);
    chk("R10", "op", int'(op), 0);
    rst_n = 1;
    // R1 difference, R2 immediate select
    a = 8'd5; b = 8'd3; step("R1");
    add_sel = 1; step("R2");
    add_sel = 0; a = 8'h80; b = 8'd127; step("R1");
    scale = 4'd15; step("R12");
    add_sel = 1; b = 8'h80; step("R12");
    scale = 4'd0; step("R12");
    // R4 over with hysteresis R5
    scale = 1; add_sel = 0; b = 0; thr = 13'd10; hyst = 13'd4;
    a = 8'd10; step("R4");
    a = 8'd11; step("R4");
    a = 8'd7;  step("R5");
    a = 8'd6;  step("R5");
    a = 8'd9;  step("R5");
    // R4/R5 under mode
    under = 1; thr = 13'h1FFB; hyst = 13'd2; a = 8'hFB; step("R4");
    a = 8'hFA; step("R4");
    a = 8'hFC; step("R5");
    a = 8'hFD; step("R5");
    // R3 magnitude mode
    under = 0; abs_m = 1; thr = 13'd20; hyst = 0; a = 8'hE0; step("R3");
    abs_m = 0; step("R3");
    a = 0; run("R3", 3);
    // R6 pickup delay 3, R7 reset delay 2
    pdly = 16'd3; rdly = 16'd2; thr = 13'd10; a = 8'd30; run("R6", 6);
    a = 0; run("R7", 5);
    // R8 cancellation
    a = 8'd30; run("R8", 2); a = 0; run("R8", 3);
    // R9 sparse ticks
    a = 8'd30;
    for (int i = 0; i < 14; i++) begin tick = (i % 3 == 0); step("R9"); end
    tick = 1; a = 0; run("R9", 5);
    // R10 block, R11 release with standing pickup
    a = 8'd30; run("R10", 5);
    blk = 1; run("R10", 3);
    blk = 0; run("R11", 6);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      a = 8'($urandom); b = 8'($urandom); add_sel = 1'($urandom);
      abs_m = 1'($urandom); under = 1'($urandom);
      scale = ($urandom % 8 == 0) ? 4'($urandom) : scale;
      if ($urandom % 50 == 0) begin
        thr = 13'($signed($urandom % 800) - 400);
        hyst = 13'($urandom % 100);
        pdly = 16'($urandom % 6); rdly = 16'($urandom % 6);
      end
      tick = ($urandom % 4) != 0;
      blk = ($urandom % 40) == 0;
      step(($urandom % 2) ? "R5" : "R6");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule